// File: doc/BRIEF.md
# Floating-Point Status Word with Compare Queue

This block holds the 32-bit floating-point status word that sits beside an arithmetic unit. When the arithmetic unit finishes an operation it reports five raw exception flags. The block reorders these flags into its own fixed order and adds them to a sticky field at the top of the word. If any new flag has its enable bit set in the low five bits of the word, the block raises a one-cycle assist trap pulse. The word also carries the rounding-mode and flush-to-zero controls. The block decodes these and drives them back to the arithmetic unit.

Compare operations finish with a two-bit relation code. A five-bit condition mask picks one result bit from that code. A nonzero target index writes the result straight into one bit of an eleven-bit result field. A zero index pushes the result into a history queue instead: the current-result bit moves into the queue head, the ten older entries shift down by one place, and the oldest entry is dropped. Software can overwrite the whole word through a write port.

Top module: `fp_status_unit`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, status_o and trap_o are zero.
- R2: Raw flag order on op_flags_i is: bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact. Internally the order is reversed: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid. On op_done_i, the flags in internal order are ORed into status bits 31:27, so inexact goes to bit 27 and invalid to bit 31. These bits are never cleared except by a software write.
- R3: trap_o is high for exactly the cycle after an op_done_i cycle in which (internal-order flags & status_o[4:0]) is nonzero. Enable bit k guards internal flag k. trap_o is low in every other cycle.
- R4: An op_done_i with all flags zero leaves status_o unchanged. With no strobe and no write, status_o holds its value.
- R5: round_mode_o equals status bits 10:9. The codes are: 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R6: ftz_o equals status bit 5. When set, it flushes both results and inputs to zero.
- R7: The compare result is picked from cmp_mask_i by cmp_rel_i: code 0 (greater) uses mask bit 4, code 1 (less) uses bit 3, code 2 (equal) uses bit 2, and code 3 (unordered) uses bit 1. Mask bit 0 only chooses a signalling compare and has no effect on the status word.
- R8: A compare with cmp_target_i = y in 1..11 writes the result to status bit 22-y and changes no other bit. A y of 12..15 changes nothing.
- R9: A compare with cmp_target_i = 0 updates three places at once. Bits 20:11 take the old bits 21:12. Bit 21 takes the old bit 26. Bit 26 takes the new result.
- R10: When sw_we_i is high, status_o takes sw_wdata_i in the next cycle. Any flag or compare update in that same cycle is discarded, and no trap follows.
- R11: When op_done_i and cmp_done_i are high together, the flags are merged first. The compare update is then applied on top, and the trap is judged as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_done_i | input | 1 | Arithmetic operation finished |
| op_flags_i | input | 5 | Raw exception flags, in raw order |
| cmp_done_i | input | 1 | Compare finished |
| cmp_rel_i | input | 2 | Relation code of the compare |
| cmp_mask_i | input | 5 | Condition mask |
| cmp_target_i | input | 4 | Target index; zero selects the queue |
| sw_we_i | input | 1 | Software write enable |
| sw_wdata_i | input | 32 | Software write data |
| status_o | output | 32 | Status word |
| round_mode_o | output | 2 | Decoded rounding mode |
| ftz_o | output | 1 | Flush-to-zero control |
| trap_o | output | 1 | Assist trap pulse |

## Verification
The software write and a hardware update can fall in the same cycle. The bench provokes this by raising sw_we_i together with op_done_i, where the op carries a flag whose enable is set. It does the same with sw_we_i and a queued compare. The check is that the next status equals the written word exactly and that trap_o stays low. The bench also drives an op and a compare in one cycle, so that the sticky merge, the queue shift and the trap all land on the same edge.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int STAT_W  = 32;
  localparam int NFLAG   = 5;
  localparam int FLAG_LSB = STAT_W - NFLAG;
  localparam int ENA_LSB = 0;
  localparam int CQ_LEN  = 10;
  localparam int CQ_LSB  = 11;
  localparam int CA_TOP  = CQ_LSB + CQ_LEN;
  localparam int CUR_BIT = 26;
  localparam int RM_LSB  = 9;
  localparam int FTZ_BIT = 5;
  localparam int YW      = 4;
  localparam int MASK_W  = 5;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } round_mode_e;

  typedef enum logic [1:0] {
    REL_GT = 2'd0,
    REL_LT = 2'd1,
    REL_EQ = 2'd2,
    REL_UN = 2'd3
  } relation_e;
endpackage

// File: rtl/fpsr_flag_merge.sv
module fpsr_flag_merge
  import fpsr_pkg::*;
#(
  parameter int N = NFLAG
) (
  input  logic         op_done_i,
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] enable_i,
  output logic [N-1:0] mapped_o,
  output logic         raise_o,
  output logic         trap_o
);
  // raw order is the reverse of the internal order
  for (genvar g = 0; g < N; g++) begin : g_map
    assign mapped_o[N-1-g] = raw_i[g];
  end

  assign raise_o = op_done_i & (|mapped_o);
  assign trap_o  = op_done_i & (|(mapped_o & enable_i));
endmodule

// File: rtl/fpsr_cmp_update.sv
module fpsr_cmp_update
  import fpsr_pkg::*;
#(
  parameter int W    = STAT_W,
  parameter int QLEN = CQ_LEN,
  parameter int QLSB = CQ_LSB,
  parameter int CUR  = CUR_BIT
) (
  input  logic [W-1:0]      status_i,
  input  logic              cmp_done_i,
  input  logic [1:0]        rel_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [YW-1:0]     y_i,
  output logic [W-1:0]      status_o
);
  localparam int TOP = QLSB + QLEN;

  relation_e rel;
  logic      res;
  logic      unused_sig_sel;

  assign rel            = relation_e'(rel_i);
  assign unused_sig_sel = mask_i[0];

  always_comb begin
    unique case (rel)
      REL_GT:  res = mask_i[4];
      REL_LT:  res = mask_i[3];
      REL_EQ:  res = mask_i[2];
      default: res = mask_i[1];
    endcase
  end

  always_comb begin
    status_o = status_i;
    if (cmp_done_i) begin
      if (y_i == '0) begin
        status_o[QLSB +: QLEN] = status_i[QLSB+1 +: QLEN];
        status_o[TOP]          = status_i[CUR];
        status_o[CUR]          = res;
      end else begin
        for (int k = 1; k <= QLEN + 1; k++) begin
          if (y_i == k[YW-1:0]) status_o[TOP+1-k] = res;
        end
      end
    end
  end
endmodule

// File: rtl/fpsr_mode_decode.sv
module fpsr_mode_decode
  import fpsr_pkg::*;
(
  input  logic [1:0] rm_field_i,
  input  logic       ftz_bit_i,
  output logic [1:0] round_mode_o,
  output logic       ftz_o
);
  round_mode_e rm;

  always_comb begin
    unique case (rm_field_i)
      2'd1:    rm = RM_ZERO;
      2'd2:    rm = RM_UP;
      2'd3:    rm = RM_DOWN;
      default: rm = RM_NEAR;
    endcase
  end

  assign round_mode_o = rm;
  assign ftz_o        = ftz_bit_i;
endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
  import fpsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_done_i,
  input  logic [NFLAG-1:0]  op_flags_i,
  input  logic              cmp_done_i,
  input  logic [1:0]        cmp_rel_i,
  input  logic [MASK_W-1:0] cmp_mask_i,
  input  logic [YW-1:0]     cmp_target_i,
  input  logic              sw_we_i,
  input  logic [STAT_W-1:0] sw_wdata_i,
  output logic [STAT_W-1:0] status_o,
  output logic [1:0]        round_mode_o,
  output logic              ftz_o,
  output logic              trap_o
);
  logic [STAT_W-1:0] status_q, after_flags, after_cmp;
  logic [NFLAG-1:0]  mapped;
  logic              raise, trap_req, trap_q;

  fpsr_flag_merge #(.N(NFLAG)) i_flag (
    .op_done_i (op_done_i),
    .raw_i     (op_flags_i),
    .enable_i  (status_q[ENA_LSB +: NFLAG]),
    .mapped_o  (mapped),
    .raise_o   (raise),
    .trap_o    (trap_req)
  );

  always_comb begin
    after_flags = status_q;
    if (raise) after_flags[FLAG_LSB +: NFLAG] = status_q[FLAG_LSB +: NFLAG] | mapped;
  end

  fpsr_cmp_update #(.W(STAT_W), .QLEN(CQ_LEN), .QLSB(CQ_LSB), .CUR(CUR_BIT)) i_cmp (
    .status_i   (after_flags),
    .cmp_done_i (cmp_done_i),
    .rel_i      (cmp_rel_i),
    .mask_i     (cmp_mask_i),
    .y_i        (cmp_target_i),
    .status_o   (after_cmp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      trap_q   <= 1'b0;
    end else if (sw_we_i) begin
      status_q <= sw_wdata_i;
      trap_q   <= 1'b0;
    end else begin
      status_q <= after_cmp;
      trap_q   <= trap_req;
    end
  end

  fpsr_mode_decode i_mode (
    .rm_field_i   (status_q[RM_LSB +: 2]),
    .ftz_bit_i    (status_q[FTZ_BIT]),
    .round_mode_o (round_mode_o),
    .ftz_o        (ftz_o)
  );

  assign status_o = status_q;
  assign trap_o   = trap_q;
endmodule

// File: rtl/fpsr_checker.sv
module fpsr_checker
  import fpsr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_done_i,
  input logic              cmp_done_i,
  input logic              sw_we_i,
  input logic [STAT_W-1:0] sw_wdata_i,
  input logic [STAT_W-1:0] status_o,
  input logic              trap_o
);
  AST_TRAP_AFTER_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(op_done_i)); // R3

  AST_STICKY_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_we_i |=> (($past(status_o[FLAG_LSB +: NFLAG]) & ~status_o[FLAG_LSB +: NFLAG]) == '0)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_done_i && !cmp_done_i && !sw_we_i) |=> $stable(status_o)); // R4

  AST_SW_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> (status_o == $past(sw_wdata_i))); // R10

  AST_SW_NO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> !trap_o); // R10

  AST_CMP_LOW_UNTOUCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_done_i && !sw_we_i) |=> $stable(status_o[CQ_LSB-1:0])); // R8
endmodule

bind fp_status_unit fpsr_checker i_fpsr_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_done_i  (op_done_i),
  .cmp_done_i (cmp_done_i),
  .sw_we_i    (sw_we_i),
  .sw_wdata_i (sw_wdata_i),
  .status_o   (status_o),
  .trap_o     (trap_o)
);

// File: tb/test_fp_status_unit.sv
module test_fp_status_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_done_i = 1'b0;
  logic [4:0]  op_flags_i = '0;
  logic        cmp_done_i = 1'b0;
  logic [1:0]  cmp_rel_i = '0;
  logic [4:0]  cmp_mask_i = '0;
  logic [3:0]  cmp_target_i = '0;
  logic        sw_we_i = 1'b0;
  logic [31:0] sw_wdata_i = '0;
  logic [31:0] status_o;
  logic [1:0]  round_mode_o;
  logic        ftz_o;
  logic        trap_o;

  fp_status_unit i_fp_status_unit (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    logic [31:0] st;
    logic        tr;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  logic [31:0] model_st = '0;
  int          n_chk = 0;
  int          n_bad = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference built from the requirement text
  task automatic drive(input logic op, input logic [4:0] fl, input logic cmp, input logic [1:0] rel,
                       input logic [4:0] mask, input logic [3:0] y, input logic we,
                       input logic [31:0] wd, input string tag);
    item_t       it;
    logic [4:0]  m;
    logic [31:0] s;
    logic        r;
    @(negedge clk_i);
    op_done_i = op; op_flags_i = fl; cmp_done_i = cmp; cmp_rel_i = rel;
    cmp_mask_i = mask; cmp_target_i = y; sw_we_i = we; sw_wdata_i = wd;
    for (int i = 0; i < 5; i++) m[4-i] = fl[i];
    s = model_st;
    it.tr = 1'b0;
    if (we) s = wd;
    else begin
      it.tr = op && ((m & model_st[4:0]) != 0);
      if (op) s[31:27] = s[31:27] | m;
      if (cmp) begin
        case (rel)
          2'd0: r = mask[4];
          2'd1: r = mask[3];
          2'd2: r = mask[2];
          default: r = mask[1];
        endcase
        if (y == 0) begin
          s[20:11] = s[21:12];
          s[21]    = s[26];
          s[26]    = r;
        end else if (y <= 11) s[22-y] = r;
      end
    end
    it.st = s;
    it.tag = tag;
    model_st = s;
    sb_q.push_back(it);
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, "R4");
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(status_o === it.st, it.tag, status_o, it.st);
        check(trap_o === it.tr, (it.tag == "R10") ? "R10" : "R3", {31'b0, trap_o}, {31'b0, it.tr});
        check(round_mode_o === it.st[10:9], "R5", {30'b0, round_mode_o}, {30'b0, it.st[10:9]});
        check(ftz_o === it.st[5], "R6", {31'b0, ftz_o}, {31'b0, it.st[5]});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired, all requirements unfinished actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(status_o === 32'h0, "R1", status_o, 32'h0);
    check(trap_o === 1'b0, "R1", {31'b0, trap_o}, 32'h0);
    rst_ni = 1'b1;
    #1;
    check(status_o === 32'h0, "R1", status_o, 32'h0);

    // R2: sticky flags, no enables
    drive(1, 5'b00001, 0, 0, 0, 0, 0, 0, "R2");
    drive(1, 5'b10000, 0, 0, 0, 0, 0, 0, "R2");
    drive(1, 5'b00001, 0, 0, 0, 0, 0, 0, "R2");
    idle();
    // R3: underflow enabled (internal bit 1), raw underflow is bit 3
    drive(0, 0, 0, 0, 0, 0, 1, 32'h0000_0002, "R10");
    drive(1, 5'b00100, 0, 0, 0, 0, 0, 0, "R3");
    drive(1, 5'b01000, 0, 0, 0, 0, 0, 0, "R3");
    drive(1, 5'b01000, 0, 0, 0, 0, 0, 0, "R3");
    idle();
    // R4: op with no flags
    drive(1, 5'b00000, 0, 0, 0, 0, 0, 0, "R4");
    // R5 / R6: mode fields
    drive(0, 0, 0, 0, 0, 0, 1, 32'h0000_0000, "R5");
    drive(0, 0, 0, 0, 0, 0, 1, 32'h0000_0200, "R5");
    drive(0, 0, 0, 0, 0, 0, 1, 32'h0000_0420, "R6");
    drive(0, 0, 0, 0, 0, 0, 1, 32'h0000_0600, "R5");
    idle();
    // R9: queued compares, more than the queue depth
    for (int i = 0; i < 13; i++)
      drive(0, 0, 1, i[1:0], (i % 3 == 0) ? 5'b10100 : 5'b01010, 0, 0, 0, "R9");
    // R7: each relation code and mask bit 0
    drive(0, 0, 1, 2'd0, 5'b10000, 4'd1, 0, 0, "R7");
    drive(0, 0, 1, 2'd1, 5'b10111, 4'd2, 0, 0, "R7");
    drive(0, 0, 1, 2'd2, 5'b00100, 4'd3, 0, 0, "R7");
    drive(0, 0, 1, 2'd3, 5'b00011, 4'd4, 0, 0, "R7");
    drive(0, 0, 1, 2'd3, 5'b00001, 4'd4, 0, 0, "R7");
    // R8: targeted bounds
    drive(0, 0, 0, 0, 0, 0, 1, 32'hA5A5_A5A5, "R10");
    drive(0, 0, 1, 2'd2, 5'b00100, 4'd11, 0, 0, "R8");
    drive(0, 0, 1, 2'd2, 5'b00000, 4'd1, 0, 0, "R8");
    drive(0, 0, 1, 2'd0, 5'b10000, 4'd6, 0, 0, "R8");
    drive(0, 0, 1, 2'd0, 5'b10000, 4'd12, 0, 0, "R8");
    drive(0, 0, 1, 2'd0, 5'b00000, 4'd15, 0, 0, "R8");
    // R10: software write collides with op and with compare
    drive(0, 0, 0, 0, 0, 0, 1, 32'h0000_001F, "R10");
    drive(1, 5'b11111, 0, 0, 0, 0, 1, 32'h0000_001F, "R10");
    drive(1, 5'b00001, 1, 2'd0, 5'b10000, 0, 1, 32'h1234_001F, "R10");
    idle();
    // R11: op and compare together, trap on invalid
    drive(1, 5'b00001, 1, 2'd1, 5'b01000, 0, 0, 0, "R11");
    drive(1, 5'b00110, 1, 2'd2, 5'b00100, 4'd5, 0, 0, "R11");
    idle();
    idle();
    wait (sb_q.size() == 0);
    @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule